// File: doc/BRIEF.md
# Training-Pattern Word Alignment Checker

This block sits on one deserialized receive lane while a link is being calibrated. The far end sends a fixed cycle of four 8-bit training words. The lane delivers 8-bit words whose bit boundary and sequence position are unknown. The checker searches every bit rotation of the two newest words, and every start position in the four-word cycle, for a run of correct words. Once it has found that run, it holds the rotation it found. It then compares each later word with the word the cycle predicts.

A calibration controller uses one checker per lane. It sets a delay tap, pulses `clear`, and waits for `done`. It then reads `pass` or `fail` for that tap and moves on to the next tap. A lane that never aligns also reports a failure, after a bounded number of words, so the sweep cannot stall.

Words arrive on a valid/ready stream. The checker applies no back-pressure while it runs. `s_ready` drops only in a cycle where `clear` is high, and a word offered in that cycle is dropped. A word counts as taken only in a cycle with `s_valid` and `s_ready` both high. Cycles with `s_valid` low change no state.

Top module: `train_word_checker`

## Requirements
- R1: After reset, `locked`, `done`, `pass` and `fail` are low. `s_ready` is high in every cycle except one with `clear` high. A word is taken only when `s_valid` and `s_ready` are both high.
- R2: The training cycle is 8'h4B, 8'h57, 8'h7C, 8'h3E, in that order, and then it repeats. Serial bit order is LSB first. The candidate word at rotation r (0 to 7) is bits r+7 down to r of {newest word, previous word}.
- R3: The first word taken after reset or clear only primes the previous-word register. `locked` rises on the edge that takes the word completing 8 consecutive in-order training words at one rotation. This holds for any start position in the cycle. An aligned stream therefore locks on its 9th word.
- R4: While locked, each taken word's candidate at the held rotation is compared with the next expected training word. Any difference sets `fail` on that edge.
- R5: `fail` and `locked` stay high until `clear` is pulsed.
- R6: A one-cycle `clear` drops `locked`, `done` and `fail`, empties the previous-word register and restarts the search.
- R7: If the 256th word taken since clear does not bring lock, `fail` and `done` both rise on that edge. After 255 such words neither is high.
- R8: `done` rises on the edge that takes the `cfg_check_words`-th compared word after lock. If `cfg_check_words` is 0, `done` rises on the lock edge. `done` holds until clear.
- R9: `pass` is high exactly when `done` is high and `fail` is low.
- R10: Idle cycles (`s_valid` low) between words change neither the lock point nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | One-cycle restart of search and result |
| cfg_check_words | input | 16 | Words to compare after lock before `done` rises |
| s_valid | input | 1 | Word offered |
| s_ready | output | 1 | Word can be taken (low during clear) |
| s_data | input | 8 | Deserialized word |
| locked | output | 1 | Rotation and cycle position found |
| done | output | 1 | Result for this setting is ready |
| pass | output | 1 | Done with no failure |
| fail | output | 1 | Sticky mismatch or lock timeout |

## Verification
The bench feeds aligned streams at every bit offset and several cycle start positions. It checks that lock appears on the 9th word and not the 8th. A design that compared against the newest word instead of the rotated window, or that counted the priming word as a match, would lock one word off or never lock. Timeout is tested at the 255/256 boundary, where an off-by-one counter would fail early or late. A single flipped bit after lock must raise a sticky `fail`, and `clear` must remove it. The bench also covers `cfg_check_words` of zero and idle gaps between words, which catch a `done` counted from the wrong edge and state that moves without `s_valid`.

// File: rtl/twc_pkg.sv
package twc_pkg;
  localparam int unsigned WORD_W  = 8;
  localparam int unsigned SEQ_LEN = 4;
  localparam int unsigned IDX_W   = $clog2(SEQ_LEN);

  typedef logic [IDX_W-1:0]  seq_idx_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic     hit;
    seq_idx_t idx;
  } seq_lookup_t;

  // Training word for a cycle position.
  function automatic word_t seq_word(input seq_idx_t i);
    case (i)
      2'd0:    return 8'h4B;
      2'd1:    return 8'h57;
      2'd2:    return 8'h7C;
      default: return 8'h3E;
    endcase
  endfunction

  // Which cycle position (if any) a word equals.
  function automatic seq_lookup_t seq_find(input word_t w);
    seq_lookup_t res;
    res = '0;
    for (int k = 0; k < SEQ_LEN; k++) begin
      if (w == seq_word(seq_idx_t'(k))) begin
        res.hit = 1'b1;
        res.idx = seq_idx_t'(k);
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/twc_rot_tracker.sv
module twc_rot_tracker
  import twc_pkg::*;
#(
  parameter int unsigned LOCK_RUN = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clear,
  input  logic     step,
  input  word_t    cand,
  output logic     lock_req,
  output seq_idx_t hit_idx
);
  localparam int unsigned RUN_W = $clog2(LOCK_RUN + 1);

  logic [RUN_W-1:0] run_q, run_n;
  seq_idx_t         last_q;
  seq_lookup_t      lk;
  logic             in_order;

  always_comb begin
    lk       = seq_find(cand);
    in_order = lk.hit && (run_q != '0) && (lk.idx == seq_idx_t'(last_q + 1'b1));
    if (!lk.hit)
      run_n = '0;
    else if (in_order)
      run_n = (run_q == RUN_W'(LOCK_RUN)) ? run_q : run_q + 1'b1;
    else
      run_n = RUN_W'(1);
    lock_req = step && lk.hit && (run_n == RUN_W'(LOCK_RUN));
    hit_idx  = lk.idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      run_q  <= '0;
      last_q <= '0;
    end else if (step) begin
      run_q  <= run_n;
      last_q <= lk.idx;
    end
  end
endmodule

// File: rtl/twc_aligner.sv
module twc_aligner
  import twc_pkg::*;
#(
  parameter int unsigned LOCK_RUN = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clear,
  input  logic     accept,
  input  word_t    data,
  output logic     locked,
  output logic     lock_now,
  output seq_idx_t lock_idx,
  output word_t    aligned
);
  localparam int unsigned ROTS  = WORD_W;
  localparam int unsigned ROT_W = $clog2(ROTS);

  word_t              prev_q;
  logic               primed_q;
  logic               locked_q;
  logic [ROT_W-1:0]   rot_q;
  logic [ROT_W-1:0]   sel;
  logic [2*WORD_W-1:0] window;
  logic               step;
  logic [ROTS-1:0]    req;
  seq_idx_t           hit_idx [ROTS];

  assign window = {data, prev_q};
  assign step   = accept && primed_q && !locked_q;

  for (genvar r = 0; r < ROTS; r++) begin : g_rot
    twc_rot_tracker #(.LOCK_RUN(LOCK_RUN)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .step     (step),
      .cand     (window[r +: WORD_W]),
      .lock_req (req[r]),
      .hit_idx  (hit_idx[r])
    );
  end

  // Lowest rotation wins if several reach the run length together.
  always_comb begin
    lock_now = 1'b0;
    sel      = '0;
    for (int r = ROTS - 1; r >= 0; r--) begin
      if (req[r]) begin
        lock_now = 1'b1;
        sel      = ROT_W'(r);
      end
    end
    lock_idx = hit_idx[sel];
  end

  assign aligned = window[rot_q +: WORD_W];
  assign locked  = locked_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      locked_q <= 1'b0;
      rot_q    <= '0;
    end else begin
      if (accept) begin
        prev_q   <= data;
        primed_q <= 1'b1;
      end
      if (lock_now) begin
        locked_q <= 1'b1;
        rot_q    <= sel;
      end
    end
  end
endmodule

// File: rtl/twc_verifier.sv
module twc_verifier
  import twc_pkg::*;
#(
  parameter int unsigned TIMEOUT_WORDS = 256,
  parameter int unsigned CFG_W         = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             accept,
  input  logic             locked,
  input  logic             lock_now,
  input  seq_idx_t         lock_idx,
  input  word_t            aligned,
  input  logic [CFG_W-1:0] cfg_check_words,
  output logic             fail,
  output logic             done
);
  localparam int unsigned TO_W = $clog2(TIMEOUT_WORDS + 1);

  seq_idx_t         exp_q;
  logic [CFG_W-1:0] chk_q;
  logic [TO_W-1:0]  wcnt_q;
  logic             fail_q, done_q;
  logic             cmp_en, mismatch, timeout, reach;
  logic [CFG_W:0]   chk_inc;

  always_comb begin
    cmp_en   = accept && locked;
    mismatch = cmp_en && (aligned != seq_word(exp_q));
    timeout  = accept && !locked && !lock_now &&
               ((wcnt_q + 1'b1) == TO_W'(TIMEOUT_WORDS));
    chk_inc  = {1'b0, chk_q} + 1'b1;
    reach    = cmp_en && (chk_inc >= {1'b0, cfg_check_words});
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      exp_q  <= '0;
      chk_q  <= '0;
      wcnt_q <= '0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (accept && !locked && (wcnt_q != TO_W'(TIMEOUT_WORDS)))
        wcnt_q <= wcnt_q + 1'b1;
      if (lock_now) begin
        exp_q <= seq_idx_t'(lock_idx + 1'b1);
        chk_q <= '0;
      end else if (cmp_en) begin
        exp_q <= seq_idx_t'(exp_q + 1'b1);
        if (chk_q != '1) chk_q <= chk_q + 1'b1;
      end
      if (mismatch || timeout) fail_q <= 1'b1;
      if (timeout || reach || (lock_now && (cfg_check_words == '0)))
        done_q <= 1'b1;
    end
  end

  assign fail = fail_q;
  assign done = done_q;
endmodule

// File: rtl/train_word_checker.sv
module train_word_checker
  import twc_pkg::*;
#(
  parameter int unsigned LOCK_RUN      = 8,
  parameter int unsigned TIMEOUT_WORDS = 256,
  parameter int unsigned CFG_W         = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CFG_W-1:0] cfg_check_words,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  output logic             locked,
  output logic             done,
  output logic             pass,
  output logic             fail
);
  logic     accept;
  logic     lock_now;
  seq_idx_t lock_idx;
  word_t    aligned;

  assign s_ready = !clear;
  assign accept  = s_valid && s_ready;

  twc_aligner #(.LOCK_RUN(LOCK_RUN)) u_align (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .accept   (accept),
    .data     (s_data),
    .locked   (locked),
    .lock_now (lock_now),
    .lock_idx (lock_idx),
    .aligned  (aligned)
  );

  twc_verifier #(.TIMEOUT_WORDS(TIMEOUT_WORDS), .CFG_W(CFG_W)) u_verify (
    .clk             (clk),
    .rst_n           (rst_n),
    .clear           (clear),
    .accept          (accept),
    .locked          (locked),
    .lock_now        (lock_now),
    .lock_idx        (lock_idx),
    .aligned         (aligned),
    .cfg_check_words (cfg_check_words),
    .fail            (fail),
    .done            (done)
  );

  assign pass = done && !fail;
endmodule

// File: rtl/twc_checker_sva.sv
module twc_checker_sva (
  input logic clk,
  input logic rst_n,
  input logic clear,
  input logic s_valid,
  input logic s_ready,
  input logic locked,
  input logic done,
  input logic pass,
  input logic fail
);
  AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!locked && !fail && !done)); // R6
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clear) |=> fail); // R5
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !clear) |=> locked); // R5
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clear) |=> done); // R8
  AST_PASS_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> locked); // R9
  AST_LOCK_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(s_valid && s_ready)); // R3
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_valid && !clear) |=> ($stable(locked) && $stable(fail) && $stable(done))); // R10
endmodule

bind train_word_checker twc_checker_sva u_sva (
  .clk     (clk),
  .rst_n   (rst_n),
  .clear   (clear),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .locked  (locked),
  .done    (done),
  .pass    (pass),
  .fail    (fail)
);

// File: tb/train_word_checker_tb_top.sv
module train_word_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic [15:0] cfg_check_words = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = '0;
  logic        locked, done, pass, fail;

  int checks = 0;
  int errors = 0;
  bit gaps_on = 1'b0;

  always #4 clk = ~clk;

  train_word_checker dut_i (
    .clk (clk), .rst_n (rst_n), .clear (clear),
    .cfg_check_words (cfg_check_words),
    .s_valid (s_valid), .s_ready (s_ready), .s_data (s_data),
    .locked (locked), .done (done), .pass (pass), .fail (fail)
  );

  function automatic logic [7:0] pat(input int i);
    case (i % 4)
      0: return 8'h4B;
      1: return 8'h57;
      2: return 8'h7C;
      default: return 8'h3E;
    endcase
  endfunction

  // Received word j when the lane's word boundary is s bits late (R2).
  function automatic logic [7:0] rx_word(input int j, input int s, input int ph);
    logic [7:0] w;
    logic [7:0] p;
    for (int i = 0; i < 8; i++) begin
      int n;
      n = 8 * j + s + i;
      p = pat(n / 8 + ph);
      w[i] = p[n % 8];
    end
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the word is taken.
  task automatic send(input logic [7:0] w);
    if (gaps_on) begin
      int g;
      g = int'($urandom_range(0, 2));
      repeat (g) @(negedge clk);
    end
    s_valid = 1'b1;
    s_data  = w;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic do_clear;
    clear   = 1'b1;
    s_valid = 1'b1;
    s_data  = 8'hA5;
    #1;
    chk(s_ready == 1'b0, "R1 ready low in clear", int'(s_ready), 0);
    @(negedge clk);
    clear   = 1'b0;
    s_valid = 1'b0;
    chk(!locked && !fail && !done, "R6 clear restarts", int'({locked, fail, done}), 0);
  endtask

  task automatic run_trial(input int s, input int ph, input int cfg, input bit flip);
    int j;
    int rot;
    j = 0;
    do_clear();
    cfg_check_words = 16'(cfg);
    rot = (8 - s) % 8;
    for (int k = 0; k < 9; k++) begin
      send(rx_word(j, s, ph));
      j++;
      if (k == 7) chk(locked == 1'b0, "R3 no lock on 8th word", int'(locked), 0);
    end
    chk(locked == 1'b1, "R3 lock on 9th word", int'(locked), 1);
    if (cfg == 0) begin
      chk(done && pass, "R8 zero count done at lock", int'({done, pass}), 3);
    end else begin
      for (int k = 0; k < cfg; k++) begin
        send(rx_word(j, s, ph));
        j++;
        if (k == cfg - 2) chk(done == 1'b0, "R8 not done early", int'(done), 0);
      end
      chk(done == 1'b1, "R8 done after count", int'(done), 1);
      chk(pass == 1'b1 && fail == 1'b0, "R9 pass on clean run", int'({pass, fail}), 2);
    end
    if (flip) begin
      int b;
      b = int'($urandom_range(0, 7));
      send(rx_word(j, s, ph) ^ (8'h01 << b));
      j++;
      repeat (2) begin
        send(rx_word(j, s, ph));
        j++;
      end
      chk(fail == 1'b1, "R4 flipped bit fails", int'(fail), 1);
      chk(pass == 1'b0, "R9 pass low on fail", int'(pass), 0);
      repeat (3) begin
        send(rx_word(j, s, ph));
        j++;
      end
      chk(fail && locked, "R5 fail and lock held", int'({fail, locked}), 3);
    end
    if (rot < 0) $display("unreachable");
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!locked && !done && !pass && !fail, "R1 reset outputs low",
        int'({locked, done, pass, fail}), 0);
    chk(s_ready == 1'b1, "R1 ready after reset", int'(s_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: every bit offset with R2 ordering.
    for (int s = 0; s < 8; s++) run_trial(s, s % 4, 3, (s % 2) == 1);
    // Zero check count.
    run_trial(5, 2, 0, 1'b0);
    // Clear after a failure.
    run_trial(1, 0, 2, 1'b1);
    do_clear();
    chk(!fail && !pass, "R6 fail dropped by clear", int'({fail, pass}), 0);

    // Random trials with idle gaps (R10).
    gaps_on = 1'b1;
    for (int t = 0; t < 10; t++) begin
      run_trial(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                int'($urandom_range(1, 20)), t % 3 == 0);
    end
    repeat (5) @(negedge clk);
    chk(locked == 1'b1, "R10 idle keeps lock", int'(locked), 1);
    gaps_on = 1'b0;

    // Timeout boundary.
    do_clear();
    for (int k = 0; k < 255; k++) send(8'h00);
    chk(!fail && !done, "R7 no timeout at 255", int'({fail, done}), 0);
    send(8'h00);
    chk(fail && done && !locked, "R7 timeout at 256", int'({fail, done, locked}), 6);
    chk(pass == 1'b0, "R9 timeout not pass", int'(pass), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule